// File: doc/BRIEF.md
# Streaming integer-to-text formatter

This block turns one binary value of up to 64 bits into printable ASCII and sends the text out one byte per cycle. The caller sets a value, its size in bits and a set of format controls, then pulses `start` while `busy` is low. The controls are the number base, the justification, the pad character, an optional minimum field width, a plus-sign flag, a zero-fill flag and a signed flag. The block captures everything on the accepting edge. It renders the digits and then offers the bytes on a valid/ready output until the last byte has been taken.

Binary, octal and hex digits are cut straight from the value's bit pattern. Decimal digits come from an iterative binary-to-BCD converter, which takes one bit per cycle. Character mode sends the value's bytes as they are. A field that is wider than the rendered text is filled with the pad character. A narrower field has no effect on the output.

Top module: `int_text_streamer`

## Requirements
- R1: While reset is asserted and after it is released, `busy` and `out_valid` are low until a start is accepted.
- R2: Base code 3 renders hex using lowercase `a`-`f`. Leading zero digits are dropped, and a zero value renders as the single character `0`.
- R3: Base code 0 (binary), 1 (octal) and 3 (hex) render the raw bit pattern of the low `size` bits. Value bits at or above `size` are ignored, and `signed_en` has no effect in these bases.
- R4: Base code 2 renders decimal. When `signed_en` is 1 and bit `size-1` is set, the value is two's complement negative and is written as `-` followed by its magnitude. Otherwise it is written unsigned. Both cases are correct up to 64 bits.
- R5: `plus_flag` puts `+` in front of a non-negative decimal value. It has no effect on negative values or on any other base.
- R6: When `zero_fill` is 1 in binary, octal or hex, leading zeros extend the digits to the digit count of a full `size`-bit value (`size`, ceil(`size`/3) or ceil(`size`/4) digits). This fill happens before field padding. `zero_fill` is ignored in decimal.
- R7: `width` (0 means no width) is a minimum field length. The rendered text is padded up to that length, and text that is already longer is neither padded nor truncated.
- R8: With right justification (`left_just`=0), `pad_zero`=1 places the sign first and then the pad zeros. `pad_zero`=0 places the pad spaces first, so the sign sits next to the digits.
- R9: With `left_just`=1, the sign and digits come first and the pad characters follow them. The pad character is `0` if `pad_zero`=1 and a space otherwise.
- R10: Base code 4 (character) sends `size`/8 bytes of the value, most significant byte first. `size` must be a multiple of 8.
- R11: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_byte` holds its value. No byte is lost or repeated.
- R12: `busy` rises on the edge that accepts `start` and falls on the edge that accepts the final byte. A `start` pulse while busy is ignored, and so are changes to the inputs while busy.
- R13: The first byte is offered after the 2nd rising edge in binary, octal, hex and character modes, and after the 67th edge (64 + 3) in decimal, counting the accepting edge as the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Request to format; accepted when `busy` is low |
| value | input | 64 | Value to render |
| size | input | 7 | Value size in bits, 1 to 64 |
| base | input | 3 | 0 binary, 1 octal, 2 decimal, 3 hex, 4 character |
| left_just | input | 1 | 1 left-justify, 0 right-justify |
| pad_zero | input | 1 | 1 pad with `0`, 0 pad with space |
| width | input | 7 | Minimum field width; 0 for none |
| plus_flag | input | 1 | Prefix `+` on non-negative decimal |
| zero_fill | input | 1 | Extend digits to full size-digit count (non-decimal) |
| signed_en | input | 1 | Treat the value as two's complement (decimal) |
| busy | output | 1 | A request is being rendered or streamed |
| out_valid | output | 1 | `out_byte` holds a character |
| out_ready | input | 1 | Sink takes the byte on this edge |
| out_byte | output | 8 | ASCII character |

## Verification
The first byte of a non-decimal request is due after the second edge, counting the accepting edge as the first. A decimal request waits for the 64-step conversion, so its first byte is due after the 67th edge. After that, one byte moves on every edge where valid and ready are both high, and `busy` must be low one edge after the last byte. The bench changes inputs and samples on the falling clock edge. It counts falling edges from the start pulse to the first valid byte and checks those two latencies exactly. It records a byte only when valid and ready are both high at that falling edge. It also checks that `busy` is low at the falling edge right after the final recorded byte.

// File: rtl/itxt_pkg.sv
package itxt_pkg;

  typedef enum logic [2:0] {
    BASE_BIN = 3'd0,
    BASE_OCT = 3'd1,
    BASE_DEC = 3'd2,
    BASE_HEX = 3'd3,
    BASE_CHR = 3'd4
  } base_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_PREP = 2'd2,
    ST_EMIT = 2'd3
  } state_e;

  // bits of source material consumed by one output character
  function automatic logic [3:0] digit_bits(input base_e b);
    case (b)
      BASE_BIN: digit_bits = 4'd1;
      BASE_OCT: digit_bits = 4'd3;
      BASE_CHR: digit_bits = 4'd8;
      default:  digit_bits = 4'd4;
    endcase
  endfunction

  function automatic logic [7:0] nibble_ascii(input logic [3:0] d);
    if (d < 4'd10) nibble_ascii = 8'h30 + {4'b0, d};
    else           nibble_ascii = 8'h57 + {4'b0, d};
  endfunction

endpackage

// File: rtl/itxt_bcd_conv.sv
module itxt_bcd_conv #(
  parameter int VAL_W = 64,
  parameter int DIG   = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [VAL_W-1:0]   bin,
  output logic               done,
  output logic [4*DIG-1:0]   bcd
);

  localparam int BCD_W = 4 * DIG;
  localparam int CNT_W = $clog2(VAL_W + 1);

  logic [VAL_W-1:0] sh_q, sh_d;
  logic [BCD_W-1:0] bcd_q, bcd_d, adj;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             act_q, act_d;
  logic             step_en;

  // add-3 correction on every BCD digit before each shift
  generate
    for (genvar g = 0; g < DIG; g++) begin : g_adj
      assign adj[4*g +: 4] = (bcd_q[4*g +: 4] >= 4'd5) ? bcd_q[4*g +: 4] + 4'd3
                                                      : bcd_q[4*g +: 4];
    end
  endgenerate

  always_comb begin
    step_en = load || (cnt_q != '0);
    sh_d    = sh_q;
    bcd_d   = bcd_q;
    cnt_d   = cnt_q;
    act_d   = act_q;
    if (load) begin
      sh_d  = bin;
      bcd_d = '0;
      cnt_d = CNT_W'(VAL_W);
      act_d = 1'b1;
    end else if (cnt_q != '0) begin
      bcd_d = BCD_W'({adj, sh_q[VAL_W-1]});
      sh_d  = sh_q << 1;
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      bcd_q <= '0;
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (step_en) begin
      sh_q  <= sh_d;
      bcd_q <= bcd_d;
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign done = act_q && (cnt_q == '0);
  assign bcd  = bcd_q;

  function automatic logic all_decimal(input logic [BCD_W-1:0] v);
    all_decimal = 1'b1;
    for (int k = 0; k < DIG; k++)
      if (v[4*k +: 4] > 4'd9) all_decimal = 1'b0;
  endfunction

  // a finished conversion holds only legal decimal digits
  assert_bcd_digits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> all_decimal(bcd_q));

endmodule

// File: rtl/itxt_len_calc.sv
module itxt_len_calc
  import itxt_pkg::*;
#(
  parameter int VAL_W = 64,
  parameter int DIG   = 20,
  parameter int SZ_W  = 7
) (
  input  base_e              base,
  input  logic [VAL_W-1:0]   raw,
  input  logic [4*DIG-1:0]   bcd,
  input  logic [SZ_W-1:0]    size,
  input  logic               zfill,
  output logic [SZ_W-1:0]    ndig
);

  logic [SZ_W-1:0] top_bit;
  logic [SZ_W-1:0] top_nib;

  always_comb begin
    top_bit = '0;
    for (int i = 0; i < VAL_W; i++)
      if (raw[i]) top_bit = SZ_W'(i);
    top_nib = '0;
    for (int k = 0; k < DIG; k++)
      if (bcd[4*k +: 4] != 4'd0) top_nib = SZ_W'(k);
  end

  always_comb begin
    case (base)
      BASE_BIN: ndig = zfill ? size : top_bit + SZ_W'(1);
      BASE_OCT: ndig = zfill ? (size + SZ_W'(2)) / SZ_W'(3)
                             : top_bit / SZ_W'(3) + SZ_W'(1);
      BASE_DEC: ndig = top_nib + SZ_W'(1);
      BASE_CHR: ndig = size >> 3;
      default:  ndig = zfill ? (size + SZ_W'(3)) >> 2
                             : (top_bit >> 2) + SZ_W'(1);
    endcase
  end

endmodule

// File: rtl/itxt_char_pick.sv
module itxt_char_pick
  import itxt_pkg::*;
#(
  parameter int VAL_W = 64,
  parameter int DIG   = 20,
  parameter int SZ_W  = 7,
  parameter int LEN_W = 8
) (
  input  base_e              base,
  input  logic [VAL_W-1:0]   raw,
  input  logic [4*DIG-1:0]   bcd,
  input  logic [LEN_W-1:0]   pos,
  input  logic [LEN_W-1:0]   tot,
  input  logic [LEN_W-1:0]   padn,
  input  logic [SZ_W-1:0]    ndig,
  input  logic               has_sign,
  input  logic [7:0]         sign_ch,
  input  logic               left,
  input  logic               pad_zero,
  output logic [7:0]         ch
);

  localparam int SRC_W = ((4 * DIG > VAL_W) ? 4 * DIG : VAL_W) + 8;
  localparam int SH_W  = LEN_W + 4;

  logic [LEN_W-1:0] sgn, nd, idx;
  logic             is_pad, is_sign;
  logic [SRC_W-1:0] src;
  logic [SH_W-1:0]  shamt;
  logic [7:0]       slice, dig_ch, pad_ch;
  logic [3:0]       d;

  // decide which part of the field the current position falls in
  always_comb begin
    sgn     = LEN_W'(has_sign);
    nd      = LEN_W'(ndig);
    is_pad  = 1'b0;
    is_sign = 1'b0;
    idx     = tot - pos - LEN_W'(1);
    if (left) begin
      idx = nd - LEN_W'(1) - (pos - sgn);
      if (pos < sgn)           is_sign = 1'b1;
      else if (pos >= sgn + nd) is_pad = 1'b1;
    end else if (pad_zero) begin
      if (pos < sgn)             is_sign = 1'b1;
      else if (pos < sgn + padn) is_pad  = 1'b1;
    end else begin
      if (pos < padn)            is_pad  = 1'b1;
      else if (pos < padn + sgn) is_sign = 1'b1;
    end
  end

  // fetch the digit or byte with index idx (0 = least significant)
  always_comb begin
    src    = (base == BASE_DEC) ? SRC_W'(bcd) : SRC_W'(raw);
    shamt  = SH_W'(idx) * SH_W'(digit_bits(base));
    slice  = 8'(src >> shamt);
    case (base)
      BASE_BIN: d = {3'b0, slice[0]};
      BASE_OCT: d = {1'b0, slice[2:0]};
      default:  d = slice[3:0];
    endcase
    dig_ch = (base == BASE_CHR) ? slice : nibble_ascii(d);
    pad_ch = pad_zero ? 8'h30 : 8'h20;
    if (is_sign)     ch = sign_ch;
    else if (is_pad) ch = pad_ch;
    else             ch = dig_ch;
  end

endmodule

// File: rtl/int_text_streamer.sv
module int_text_streamer
  import itxt_pkg::*;
#(
  parameter int VAL_W = 64,
  parameter int WID_W = 7,
  localparam int SZ_W = $clog2(VAL_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [VAL_W-1:0]   value,
  input  logic [SZ_W-1:0]    size,
  input  logic [2:0]         base,
  input  logic               left_just,
  input  logic               pad_zero,
  input  logic [WID_W-1:0]   width,
  input  logic               plus_flag,
  input  logic               zero_fill,
  input  logic               signed_en,
  output logic               busy,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [7:0]         out_byte
);

  localparam int BCD_DIG = (VAL_W * 31) / 100 + 1;
  localparam int BCD_W   = 4 * BCD_DIG;
  localparam int LEN_W   = ((WID_W > SZ_W) ? WID_W : SZ_W) + 1;

  // reset: asserted at once, released through two flops
  logic [1:0] rsync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  state_e           state_q, state_d;
  logic [VAL_W-1:0] raw_q;
  base_e            base_q;
  logic [SZ_W-1:0]  size_q;
  logic             left_q, padz_q, zf_q, sgn_q;
  logic [WID_W-1:0] width_q;
  logic [7:0]       sgnch_q;
  logic [SZ_W-1:0]  nd_q;
  logic [LEN_W-1:0] tot_q, padn_q, pos_q;

  logic             ld_en, prep_en, pos_en, accept, last_pos, conv_done;
  logic             is_dec, topb, neg, sgn_d;
  base_e            base_in;
  logic [VAL_W-1:0] mask, masked, mag;
  logic [7:0]       sgnch_d;
  logic [SZ_W-1:0]  nd_w;
  logic [LEN_W-1:0] len_w, padn_d, tot_d, pos_d;
  logic [BCD_W-1:0] bcd_w;

  // capture-side arithmetic: mask to size, take magnitude, pick the sign
  always_comb begin
    base_in = base_e'(base);
    is_dec  = (base_in == BASE_DEC);
    mask    = (size >= SZ_W'(VAL_W)) ? '1 : ((VAL_W'(1) << size) - VAL_W'(1));
    masked  = value & mask;
    topb    = |(masked & ~(mask >> 1));
    neg     = is_dec && signed_en && topb;
    mag     = neg ? ((~masked + VAL_W'(1)) & mask) : masked;
    sgn_d   = is_dec && (neg || plus_flag);
    sgnch_d = neg ? 8'h2D : 8'h2B;
  end

  itxt_bcd_conv #(.VAL_W(VAL_W), .DIG(BCD_DIG)) u_bcd (
    .clk   (clk),
    .rst_n (rst_i_n),
    .load  (ld_en && is_dec),
    .bin   (mag),
    .done  (conv_done),
    .bcd   (bcd_w)
  );

  itxt_len_calc #(.VAL_W(VAL_W), .DIG(BCD_DIG), .SZ_W(SZ_W)) u_len (
    .base  (base_q),
    .raw   (raw_q),
    .bcd   (bcd_w),
    .size  (size_q),
    .zfill (zf_q),
    .ndig  (nd_w)
  );

  itxt_char_pick #(.VAL_W(VAL_W), .DIG(BCD_DIG), .SZ_W(SZ_W), .LEN_W(LEN_W)) u_pick (
    .base     (base_q),
    .raw      (raw_q),
    .bcd      (bcd_w),
    .pos      (pos_q),
    .tot      (tot_q),
    .padn     (padn_q),
    .ndig     (nd_q),
    .has_sign (sgn_q),
    .sign_ch  (sgnch_q),
    .left     (left_q),
    .pad_zero (padz_q),
    .ch       (out_byte)
  );

  assign out_valid = (state_q == ST_EMIT);
  assign busy      = (state_q != ST_IDLE);
  assign accept    = out_valid && out_ready;
  assign last_pos  = (pos_q == tot_q - LEN_W'(1));

  // next-state logic
  always_comb begin
    state_d = state_q;
    ld_en   = 1'b0;
    prep_en = 1'b0;
    case (state_q)
      ST_IDLE: if (start) begin
        ld_en   = 1'b1;
        state_d = is_dec ? ST_CONV : ST_PREP;
      end
      ST_CONV: if (conv_done) state_d = ST_PREP;
      ST_PREP: begin
        prep_en = 1'b1;
        state_d = ST_EMIT;
      end
      ST_EMIT: if (accept && last_pos) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // field geometry and output position
  always_comb begin
    len_w  = LEN_W'(nd_w) + LEN_W'(sgn_q);
    padn_d = (LEN_W'(width_q) > len_w) ? LEN_W'(width_q) - len_w : '0;
    tot_d  = len_w + padn_d;
    pos_en = prep_en || accept;
    pos_d  = prep_en ? '0 : pos_q + LEN_W'(1);
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_IDLE;
      raw_q   <= '0;
      base_q  <= BASE_BIN;
      size_q  <= '0;
      left_q  <= 1'b0;
      padz_q  <= 1'b0;
      zf_q    <= 1'b0;
      sgn_q   <= 1'b0;
      width_q <= '0;
      sgnch_q <= '0;
      nd_q    <= '0;
      tot_q   <= '0;
      padn_q  <= '0;
      pos_q   <= '0;
    end else begin
      state_q <= state_d;
      if (ld_en) begin
        raw_q   <= mag;
        base_q  <= base_in;
        size_q  <= size;
        left_q  <= left_just;
        padz_q  <= pad_zero;
        zf_q    <= zero_fill && !is_dec;
        sgn_q   <= sgn_d;
        width_q <= width;
        sgnch_q <= sgnch_d;
      end
      if (prep_en) begin
        nd_q   <= nd_w;
        tot_q  <= tot_d;
        padn_q <= padn_d;
      end
      if (pos_en) pos_q <= pos_d;
    end
  end

  assert_stall_hold_R11: assert property (@(posedge clk) disable iff (!rst_i_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte)));

  assert_valid_in_busy_R12: assert property (@(posedge clk) disable iff (!rst_i_n)
    out_valid |-> busy);

  assert_busy_from_start_R12: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(busy) |-> $past(start));

  assert_field_len_R7: assert property (@(posedge clk) disable iff (!rst_i_n)
    out_valid |-> ((tot_q >= LEN_W'(nd_q) + LEN_W'(sgn_q)) && (tot_q >= LEN_W'(width_q))));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_i_n)
    !busy |-> !out_valid);

endmodule

// File: tb/int_text_streamer_test.sv
`timescale 1ns/1ps
module int_text_streamer_test;

  localparam int VAL_W = 64;
  localparam int WID_W = 7;
  localparam int SZ_W  = 7;
  localparam int XL    = 24;
  localparam int NV    = 23;

  typedef struct packed {
    logic [63:0]     val;
    logic [6:0]      sz;
    logic [2:0]      bs;
    logic            lj;
    logic            pz;
    logic [6:0]      wd;
    logic            pl;
    logic            zf;
    logic            sg;
    logic [8*XL-1:0] txt;
    logic [7:0]      req;
  } vec_t;

  // base: 0 bin, 1 oct, 2 dec, 3 hex, 4 char
  localparam vec_t VECS [NV] = '{
    '{64'h0A, 7'd8, 3'd3, 1'b0, 1'b1, 7'd2, 1'b0, 1'b0, 1'b0, "0a", 8'd7},                  // R7 R2
    '{64'h0, 7'd16, 3'd3, 1'b0, 1'b0, 7'd0, 1'b0, 1'b0, 1'b0, "0", 8'd2},                   // R2
    '{64'hBEEF, 7'd16, 3'd3, 1'b0, 1'b0, 7'd0, 1'b0, 1'b0, 1'b1, "beef", 8'd3},             // R3 R2
    '{64'hAB, 7'd16, 3'd3, 1'b1, 1'b0, 7'd10, 1'b0, 1'b1, 1'b0, "00ab      ", 8'd6},        // R6 R9
    '{64'h5, 7'd8, 3'd0, 1'b0, 1'b0, 7'd0, 1'b0, 1'b0, 1'b0, "101", 8'd3},                  // R3
    '{64'h5, 7'd8, 3'd0, 1'b0, 1'b0, 7'd0, 1'b0, 1'b1, 1'b0, "00000101", 8'd6},             // R6
    '{64'h1FF, 7'd8, 3'd1, 1'b0, 1'b0, 7'd0, 1'b0, 1'b0, 1'b0, "377", 8'd3},                // R3 masking
    '{64'h8, 7'd8, 3'd1, 1'b0, 1'b0, 7'd0, 1'b0, 1'b1, 1'b0, "010", 8'd6},                  // R6
    '{64'hFF, 7'd8, 3'd2, 1'b0, 1'b0, 7'd0, 1'b0, 1'b0, 1'b0, "255", 8'd4},                 // R4
    '{64'hFF, 7'd8, 3'd2, 1'b0, 1'b0, 7'd0, 1'b0, 1'b0, 1'b1, "-1", 8'd4},                  // R4
    '{64'h80, 7'd8, 3'd2, 1'b0, 1'b1, 7'd6, 1'b0, 1'b0, 1'b1, "-00128", 8'd8},              // R8
    '{64'h80, 7'd8, 3'd2, 1'b0, 1'b0, 7'd6, 1'b0, 1'b0, 1'b1, "  -128", 8'd8},              // R8
    '{64'd42, 7'd32, 3'd2, 1'b1, 1'b0, 7'd6, 1'b1, 1'b0, 1'b0, "+42   ", 8'd5},             // R5 R9
    '{64'd42, 7'd8, 3'd3, 1'b0, 1'b0, 7'd0, 1'b1, 1'b0, 1'b1, "2a", 8'd5},                  // R5 R3
    '{64'hFFFF_FFFF_FFFF_FFFF, 7'd64, 3'd2, 1'b0, 1'b0, 7'd0, 1'b0, 1'b0, 1'b0,
      "18446744073709551615", 8'd4},                                                         // R4
    '{64'h8000_0000_0000_0000, 7'd64, 3'd2, 1'b0, 1'b0, 7'd0, 1'b0, 1'b0, 1'b1,
      "-9223372036854775808", 8'd4},                                                         // R4
    '{64'h4869, 7'd16, 3'd4, 1'b0, 1'b0, 7'd0, 1'b0, 1'b0, 1'b0, "Hi", 8'd10},              // R10
    '{64'h414243, 7'd24, 3'd4, 1'b0, 1'b0, 7'd5, 1'b0, 1'b0, 1'b0, "  ABC", 8'd10},         // R10 R7
    '{64'd12345, 7'd16, 3'd2, 1'b0, 1'b0, 7'd3, 1'b0, 1'b1, 1'b0, "12345", 8'd7},           // R7 R6
    '{64'd0, 7'd8, 3'd2, 1'b0, 1'b0, 7'd0, 1'b1, 1'b0, 1'b0, "+0", 8'd5},                   // R5
    '{64'd7, 7'd8, 3'd2, 1'b1, 1'b1, 7'd3, 1'b0, 1'b0, 1'b0, "700", 8'd9},                  // R9
    '{64'hFF, 7'd8, 3'd2, 1'b0, 1'b0, 7'd0, 1'b1, 1'b0, 1'b1, "-1", 8'd5},                  // R5
    '{64'h7F, 7'd8, 3'd2, 1'b0, 1'b1, 7'd5, 1'b1, 1'b0, 1'b1, "+0127", 8'd8}                // R8
  };

  logic             clk = 1'b0;
  logic             rst_n;
  logic             start;
  logic [VAL_W-1:0] value;
  logic [SZ_W-1:0]  size;
  logic [2:0]       base;
  logic             left_just, pad_zero, plus_flag, zero_fill, signed_en;
  logic [WID_W-1:0] width;
  logic             busy, out_valid, out_ready;
  logic [7:0]       out_byte;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  int_text_streamer #(.VAL_W(VAL_W), .WID_W(WID_W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .value(value), .size(size), .base(base),
    .left_just(left_just), .pad_zero(pad_zero), .width(width), .plus_flag(plus_flag),
    .zero_fill(zero_fill), .signed_en(signed_en), .busy(busy), .out_valid(out_valid),
    .out_ready(out_ready), .out_byte(out_byte)
  );

  task automatic check(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s", msg);
    end
  endtask

  function automatic int text_len(input logic [8*XL-1:0] t);
    int n = 0;
    for (int i = 0; i < XL; i++) if (t[8*i +: 8] != 8'h00) n++;
    return n;
  endfunction

  task automatic drive(input vec_t v);
    value = v.val; size = v.sz; base = v.bs; left_just = v.lj; pad_zero = v.pz;
    width = v.wd; plus_flag = v.pl; zero_fill = v.zf; signed_en = v.sg;
  endtask

  // called at a falling edge after the start pulse has been removed
  task automatic collect(input vec_t v, input bit stall, input bit poke,
                         output logic [8*XL-1:0] got, output int n, output bit last_acc);
    int cyc = 0;
    got = '0; n = 0; last_acc = 1'b0;
    while (busy === 1'b1) begin
      out_ready = stall ? ((cyc % 3) != 1) : 1'b1;
      if (poke && cyc == 2) begin start = 1'b1; value = ~v.val; base = 3'd2; end
      if (poke && cyc == 3) begin start = 1'b0; value = v.val; base = v.bs; end
      last_acc = 1'b0;
      if (out_valid && out_ready) begin
        got = {got[8*XL-9:0], out_byte};
        n++;
        last_acc = 1'b1;
      end
      cyc++;
      @(negedge clk);
    end
    out_ready = 1'b0;
    start = 1'b0;
  endtask

  task automatic judge(input vec_t v, input logic [8*XL-1:0] got, input int n,
                       input bit last_acc, input string tag);
    check(n == text_len(v.txt) && got == v.txt,
          $sformatf("%s text: actual \"%0s\" (%0d bytes) expected \"%0s\" (%0d bytes)",
                    tag, got, n, v.txt, text_len(v.txt)));
    check(last_acc, $sformatf("R12 busy after final byte: actual still busy or idle early, expected low right after last byte (%s)", tag));
  endtask

  task automatic do_case(input vec_t v, input bit stall, input bit poke, input string tag);
    logic [8*XL-1:0] got;
    int n;
    bit la;
    @(negedge clk);
    drive(v);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    collect(v, stall, poke, got, n, la);
    judge(v, got, n, la, tag);
  endtask

  task automatic latency_case(input vec_t v, input int expect_edges, input string tag);
    logic [8*XL-1:0] got;
    int n, cnt;
    bit la;
    @(negedge clk);
    drive(v);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 1;
    while (out_valid !== 1'b1 && cnt < 500) begin
      @(negedge clk);
      cnt++;
    end
    check(cnt == expect_edges, $sformatf("R13 %s first byte after edge: actual %0d expected %0d",
                                         tag, cnt, expect_edges));
    // R11: hold ready low, byte must stay put
    for (int k = 0; k < 5; k++) begin
      check(out_valid === 1'b1 && out_byte == v.txt[8*(text_len(v.txt)-1) +: 8],
            $sformatf("R11 stall %0d: actual valid=%b byte=%h expected valid=1 byte=%h",
                      k, out_valid, out_byte, v.txt[8*(text_len(v.txt)-1) +: 8]));
      @(negedge clk);
    end
    collect(v, 1'b0, 1'b0, got, n, la);
    judge(v, got, n, la, tag);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL R12 watchdog: actual busy never cleared, expected run to finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    vec_t hv, dv;
    rst_n = 1'b0; start = 1'b0; out_ready = 1'b0;
    drive(VECS[0]);
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && out_valid === 1'b0,
          $sformatf("R1 in reset: actual busy=%b valid=%b expected 0 0", busy, out_valid));
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(busy === 1'b0 && out_valid === 1'b0,
          $sformatf("R1 after reset: actual busy=%b valid=%b expected 0 0", busy, out_valid));

    // table walk; odd entries run with a stalling sink (R11)
    for (int i = 0; i < NV; i++)
      do_case(VECS[i], (i % 2) == 1, 1'b0, $sformatf("R%0d vec%0d", VECS[i].req, i));

    // R12: start pulse and input changes while busy are ignored
    do_case(VECS[2], 1'b1, 1'b1, "R12 start while busy");
    do_case(VECS[12], 1'b0, 1'b1, "R12 start while busy dec");

    // R13 latency and R11 hold, hex then decimal
    hv = VECS[2];
    latency_case(hv, 2, "hex");
    dv = VECS[8];
    latency_case(dv, VAL_W + 3, "dec");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule